// File: doc/BRIEF.md
# Triple-Buffered Pin-Mask Sequence Player

This block drives a 32-bit output port from a stored list of steps. Each step pairs a pin-state mask with a hold count. The player walks the list in order and loops forever, advancing only on a clock-enable tick. By placing one rising and one falling step per channel at chosen points in the list, a single player produces many PWM channels at once, with any phase offset.

Three step lists are kept in internal storage. A writer fills one list through the write port, sets its length, and then issues a commit strobe to mark it as the newest. The block publishes the list the writer should fill next. This target is never the list that is playing and never the newest pending one. The player reads the commit only when a pass completes, so a new set of duty cycles always takes effect on a pass boundary and never in the middle of a period.

Top module: `seq_player`

## Requirements
- R1: After reset, `pins` is 0, `play_buf` and `last_buf` are 0, and each of the three lists holds a single step with mask 0 and hold count 10 (length 1). The first list swap can therefore happen no earlier than the 11th tick.
- R2: A step's mask is held on `pins` for exactly hold+1 ticks, where a tick is a rising clock edge with `tick` high. `pins` changes only on a tick edge.
- R3: The steps of a list are played in index order 0, 1, ..., length-1. Play then wraps to index 0.
- R4: When a pass ends, `play_buf` takes the value of `last_buf` as it was before that edge. If the two are equal, the same list replays. A commit during a pass does not change `play_buf` before the pass ends, and only the newest commit counts.
- R5: `tgt_buf` equals (play_buf+1) mod 3. If that value equals `last_buf`, it is advanced once more, mod 3.
- R6: A stored length of 0 plays as 1. A length above 64 plays as 64.
- R7: A step write, length write or commit with `wr_buf` = 3 has no effect.
- R8: A commit with `wr_buf` in 0..2 sets `last_buf` to `wr_buf` on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Step-rate clock enable |
| wr_en | input | 1 | Write the step at (`wr_buf`, `wr_idx`) |
| wr_buf | input | 2 | List index (0..2) for writes, length writes and commits |
| wr_idx | input | 6 | Step index within the list |
| wr_mask | input | 32 | Pin mask of the written step |
| wr_delay | input | 32 | Hold count of the written step |
| size_en | input | 1 | Write the length of list `wr_buf` |
| size_val | input | 7 | Length value |
| commit | input | 1 | Mark list `wr_buf` as newest |
| pins | output | 32 | Pin outputs |
| play_buf | output | 2 | List currently playing |
| last_buf | output | 2 | Newest committed list |
| tgt_buf | output | 2 | List the writer should fill next |

## Verification
A behavioural reference model is compared with the outputs on every clock.

The stimulus covers several cases:
- A three-step list with unequal hold counts under a slow tick. This separates off-by-one errors in the hold time from errors in step order.
- A zero-length list under a tick on every cycle. This shows whether the player stalls or runs off the end of the list.
- A 64-step list given an oversized length. This tests the clamp and the full-depth wrap.
- Writes and commits to the nonexistent fourth list.
- Two commits within one pass. This shows whether the newest commit wins at the boundary and whether the writer target moves to the remaining list.

// File: rtl/seq_player.sv
module seq_player #(
  parameter int PINS      = 32,
  parameter int DLY_W     = 32,
  parameter int DEPTH     = 64,
  parameter int RST_DELAY = 10
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tick,
  input  logic                         wr_en,
  input  logic [1:0]                   wr_buf,
  input  logic [$clog2(DEPTH)-1:0]     wr_idx,
  input  logic [PINS-1:0]              wr_mask,
  input  logic [DLY_W-1:0]             wr_delay,
  input  logic                         size_en,
  input  logic [$clog2(DEPTH+1)-1:0]   size_val,
  input  logic                         commit,
  output logic [PINS-1:0]              pins,
  output logic [1:0]                   play_buf,
  output logic [1:0]                   last_buf,
  output logic [1:0]                   tgt_buf
);
  localparam int NB = 3;
  localparam int BW = 2;
  localparam int IW = $clog2(DEPTH);
  localparam int SW = $clog2(DEPTH + 1);
  localparam int AW = $clog2(NB * DEPTH);

  logic [PINS-1:0]  mmask [NB*DEPTH];
  logic [DLY_W-1:0] mdly  [NB*DEPTH];
  logic [SW-1:0]    msize [NB];

  logic [IW-1:0]    idx;
  logic [DLY_W-1:0] cnt, cur_dly;

  function automatic logic [AW-1:0] at(input logic [BW-1:0] b, input logic [IW-1:0] i);
    return AW'(b) * AW'(DEPTH) + AW'(i);
  endfunction

  wire            wr_ok = (wr_buf < BW'(NB));
  wire [SW-1:0]   sz    = msize[play_buf];
  wire [SW-1:0]   eff   = (sz == '0) ? SW'(1) : ((sz > SW'(DEPTH)) ? SW'(DEPTH) : sz);
  wire            wrap  = (SW'(idx) + SW'(1)) >= eff;
  wire            step  = tick && (cnt == cur_dly);
  wire [BW-1:0]   nbuf  = wrap ? last_buf : play_buf;
  wire [IW-1:0]   nidx  = wrap ? '0 : idx + IW'(1);
  wire [AW-1:0]   naddr = at(nbuf, nidx);

  wire [BW-1:0]   t1    = (play_buf == BW'(NB-1)) ? '0 : play_buf + BW'(1);
  assign tgt_buf = (t1 == last_buf) ? ((t1 == BW'(NB-1)) ? '0 : t1 + BW'(1)) : t1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NB*DEPTH; k++) begin
        mmask[k] <= '0;
        mdly[k]  <= (k % DEPTH == 0) ? DLY_W'(RST_DELAY) : '0;
      end
      for (int b = 0; b < NB; b++) msize[b] <= SW'(1);
    end else begin
      if (wr_en && wr_ok) begin
        mmask[at(wr_buf, wr_idx)] <= wr_mask;
        mdly[at(wr_buf, wr_idx)]  <= wr_delay;
      end
      if (size_en && wr_ok) msize[wr_buf] <= size_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins     <= '0;
      cur_dly  <= DLY_W'(RST_DELAY);
      cnt      <= '0;
      idx      <= '0;
      play_buf <= '0;
      last_buf <= '0;
    end else begin
      if (step) begin
        play_buf <= nbuf;
        idx      <= nidx;
        pins     <= mmask[naddr];
        cur_dly  <= mdly[naddr];
        cnt      <= '0;
      end else if (tick) begin
        cnt <= cnt + DLY_W'(1);
      end
      if (commit && wr_ok) last_buf <= wr_buf;
    end
  end
endmodule

module seq_player_chk #(
  parameter int PINS = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tick,
  input logic            commit,
  input logic [1:0]      wr_buf,
  input logic [PINS-1:0] pins,
  input logic [1:0]      play_buf,
  input logic [1:0]      last_buf,
  input logic [1:0]      tgt_buf
);
  // R1
  rst_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pins == '0 && play_buf == 2'd0 && last_buf == 2'd0));

  // R2
  pins_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pins) |-> $past(tick));

  // R4
  swap_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(play_buf) |-> (play_buf == $past(last_buf) && $past(tick)));

  // R5
  tgt_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_buf != play_buf && tgt_buf != last_buf && tgt_buf != 2'd3));

  // R8
  commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && wr_buf != 2'd3) |=> last_buf == $past(wr_buf));

  // R7
  bad_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && wr_buf == 2'd3) |=> $stable(last_buf));
endmodule

bind seq_player seq_player_chk #(.PINS(PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .commit(commit), .wr_buf(wr_buf),
  .pins(pins), .play_buf(play_buf), .last_buf(last_buf), .tgt_buf(tgt_buf)
);

// File: tb/sim_seq_player.sv
module sim_seq_player;
  localparam int CLK_P = 10;

  logic        clk = 0, rst_n = 0, tick = 0;
  logic        wr_en = 0, size_en = 0, commit = 0;
  logic [1:0]  wr_buf = 0;
  logic [5:0]  wr_idx = 0;
  logic [31:0] wr_mask = 0, wr_delay = 0;
  logic [6:0]  size_val = 0;
  logic [31:0] pins;
  logic [1:0]  play_buf, last_buf, tgt_buf;

  int total = 0, bad = 0, tdiv = 3, cyc = 0, tick_total = 0;
  bit done = 0;

  seq_player u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_buf(wr_buf),
    .wr_idx(wr_idx), .wr_mask(wr_mask), .wr_delay(wr_delay), .size_en(size_en),
    .size_val(size_val), .commit(commit), .pins(pins), .play_buf(play_buf),
    .last_buf(last_buf), .tgt_buf(tgt_buf)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(negedge clk) begin
    cyc++;
    tick = (tdiv <= 1) || (cyc % tdiv == 0);
  end

  always @(posedge clk) if (rst_n && tick) tick_total <= tick_total + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // behavioural reference
  logic [31:0] mm [3][64];
  logic [31:0] md [3][64];
  int ms [3];
  int mb, mlw, midx;
  logic [31:0] mcnt, mdl, mcur;

  function automatic int eff_len(input int s);
    if (s == 0) return 1;
    if (s > 64) return 64;
    return s;
  endfunction

  function automatic int exp_tgt();
    for (int k = 1; k < 3; k++)
      if ((mb + k) % 3 != mlw) return (mb + k) % 3;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < 3; b++) begin
        ms[b] = 1;
        for (int i = 0; i < 64; i++) begin
          mm[b][i] = 0;
          md[b][i] = (i == 0) ? 10 : 0;
        end
      end
      mb = 0; mlw = 0; midx = 0; mcnt = 0; mdl = 10; mcur = 0;
    end else begin
      if (tick) begin
        if (mcnt == mdl) begin
          if (midx + 1 >= eff_len(ms[mb])) begin
            mb = mlw;
            midx = 0;
          end else midx++;
          mcur = mm[mb][midx];
          mdl = md[mb][midx];
          mcnt = 0;
        end else mcnt++;
      end
      if (wr_en && wr_buf != 3) begin
        mm[wr_buf][wr_idx] = wr_mask;
        md[wr_buf][wr_idx] = wr_delay;
      end
      if (size_en && wr_buf != 3) ms[wr_buf] = int'(size_val);
      if (commit && wr_buf != 3) mlw = int'(wr_buf);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(pins == mcur, "R2/R3 pins vs model", pins, mcur);
      chk(play_buf == 2'(mb), "R4 play_buf vs model", 32'(play_buf), 32'(mb));
      chk(last_buf == 2'(mlw), "R8 last_buf vs model", 32'(last_buf), 32'(mlw));
      chk(tgt_buf == 2'(exp_tgt()), "R5 tgt_buf vs model", 32'(tgt_buf), 32'(exp_tgt()));
    end
  end

  task automatic put(input logic [1:0] b, input int i, input logic [31:0] m, input logic [31:0] d);
    wr_en = 1; wr_buf = b; wr_idx = 6'(i); wr_mask = m; wr_delay = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic set_len(input logic [1:0] b, input int n);
    size_en = 1; wr_buf = b; size_val = 7'(n);
    @(negedge clk);
    size_en = 0;
  endtask

  task automatic do_commit(input logic [1:0] b);
    commit = 1; wr_buf = b;
    @(negedge clk);
    commit = 0;
  endtask

  task automatic wait_pins(input logic [31:0] m);
    for (int t = 0; t < 5000 && pins != m; t++) @(negedge clk);
  endtask

  task automatic wait_play(input logic [1:0] b);
    for (int t = 0; t < 5000 && play_buf != b; t++) @(negedge clk);
  endtask

  task automatic hold_len(input logic [31:0] m, output int n);
    wait_pins(m);
    n = 0;
    while (pins == m && n < 1000) begin
      @(posedge clk);
      if (tick) n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int n;
    repeat (4) @(negedge clk);
    rst_n = 1;
    chk(pins == 0 && play_buf == 0 && last_buf == 0, "R1 reset state",
        {pins[27:0], play_buf, last_buf}, 32'h0);
    chk(tgt_buf == 2'd1, "R5 target after reset", 32'(tgt_buf), 32'd1);

    put(2'd1, 0, 32'h0000_0005, 32'd2);
    put(2'd1, 1, 32'h0000_0002, 32'd0);
    put(2'd1, 2, 32'h8000_0001, 32'd4);
    set_len(2'd1, 3);
    do_commit(2'd1);
    chk(play_buf == 0 && last_buf == 1, "R4 commit mid-pass keeps playing list",
        32'(play_buf), 32'd0);
    wait_play(2'd1);
    chk(tick_total == 11, "R1 first swap after 11 ticks", 32'(tick_total), 32'd11);
    chk(pins == 32'h0000_0005, "R3 first step after swap", pins, 32'h5);
    hold_len(32'h0000_0005, n); chk(n == 3, "R2 hold of 2 lasts 3 ticks", 32'(n), 32'd3);
    hold_len(32'h0000_0002, n); chk(n == 1, "R2 hold of 0 lasts 1 tick", 32'(n), 32'd1);
    hold_len(32'h8000_0001, n); chk(n == 5, "R2 hold of 4 lasts 5 ticks", 32'(n), 32'd5);
    chk(pins == 32'h0000_0005, "R3 wrap back to step 0", pins, 32'h5);

    tdiv = 1;
    chk(tgt_buf == 2'd2, "R5 target with play=last=1", 32'(tgt_buf), 32'd2);
    put(2'd2, 0, 32'hDEAD_0000, 32'd1);
    set_len(2'd2, 0);
    do_commit(2'd2);
    wait_play(2'd2);
    chk(play_buf == 2'd2, "R4 swap to newest list", 32'(play_buf), 32'd2);
    wait_pins(32'hDEAD_0000);
    n = 0;
    for (int t = 0; t < 20; t++) begin
      @(negedge clk);
      if (pins == 32'hDEAD_0000) n++;
    end
    chk(n == 20, "R6 zero length plays one step", 32'(n), 32'd20);

    chk(tgt_buf == 2'd0, "R5 target with play=last=2", 32'(tgt_buf), 32'd0);
    for (int i = 0; i < 64; i++) put(2'd0, i, 32'h100 + i, 32'd0);
    set_len(2'd0, 70);
    do_commit(2'd0);
    wait_play(2'd0);
    wait_pins(32'h100);
    n = 0;
    do begin
      @(posedge clk);
      if (tick) n++;
      @(negedge clk);
    end while (pins != 32'h100 && n < 500);
    chk(n == 64, "R6 oversized length clamps to 64", 32'(n), 32'd64);

    put(2'd3, 0, 32'hFFFF_FFFF, 32'd7);
    set_len(2'd3, 5);
    do_commit(2'd3);
    chk(last_buf == 2'd0, "R7 commit to index 3 ignored", 32'(last_buf), 32'd0);
    chk(tgt_buf == 2'd1, "R7 target unchanged after index 3", 32'(tgt_buf), 32'd1);

    put(2'd1, 0, 32'h0BAD_0001, 32'd2);
    set_len(2'd1, 1);
    do_commit(2'd1);
    chk(last_buf == 2'd1, "R8 commit sets last_buf", 32'(last_buf), 32'd1);
    chk(tgt_buf == 2'd2, "R5 target skips newest", 32'(tgt_buf), 32'd2);
    put(2'd2, 0, 32'h0600_0D00, 32'd3);
    set_len(2'd2, 1);
    do_commit(2'd2);
    chk(play_buf == 2'd0, "R4 still on list 0 mid-pass", 32'(play_buf), 32'd0);
    for (int t = 0; t < 5000 && play_buf == 2'd0; t++) @(negedge clk);
    chk(play_buf == 2'd2, "R4 newest of two commits wins", 32'(play_buf), 32'd2);
    chk(pins == 32'h0600_0D00, "R3 newest list step 0 shown", pins, 32'h0600_0D00);
    repeat (20) @(negedge clk);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired act=%0d exp=finished", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule